// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block picks one interrupt to hand to the CPU out of eight maskable sources and one non-maskable source. A maskable source makes a request only while its condition input and its enable input are both high. Each source also has a one-bit priority level. The non-maskable source is captured on its rising edge.

The surviving request is checked against two mask bits taken from the CPU's condition-code register. These bits define three states:

- everything open;
- only level-1 requests open;
- only the non-maskable source open.

A request that is selected but masked stays pending.

Acceptance waits for the CPU to flag an instruction boundary. When a request is accepted, the block pulses an accept strobe together with:

- the vector number of the accepted source;
- a one-hot acknowledge toward that source;
- a request to set both mask bits.

Top module: `irq2_arbiter`

## Requirements
- R1: After reset, accept_o, mask_set_o and src_ack_o are all 0.
- R2: A maskable source k takes part in arbitration only while src_req_i[k] and src_en_i[k] are both 1; with the enable at 0 it is never accepted.
- R3: Among active maskable requests, one whose src_lvl_i bit is 1 wins over any whose bit is 0.
- R4: Among active requests of equal level, the lowest source index wins.
- R5: A request that loses arbitration stays pending and is accepted at a later boundary once the winner is gone.
- R6: With imask_i = 0, the selected request is accepted whatever its level and whatever umask_i is.
- R7: With imask_i = 1 and umask_i = 0, only level-1 maskable requests are accepted; level-0 requests stay pending.
- R8: With imask_i = 1 and umask_i = 1, no maskable request is accepted; only the non-maskable source can be.
- R9: Acceptance is decided only on a clock edge at which insn_done_i is 1. accept_o is high in the cycle after that edge and is never high otherwise.
- R10: On acceptance, vec_o = VEC_BASE + k for maskable source k (16 + k by default), src_ack_o has only bit k set, and mask_set_o is 1 (asking the CPU to set both mask bits).
- R11: A rising edge on nmi_i beats every maskable request and ignores both mask bits. It is accepted with vec_o = NMI_VEC (7 by default) and src_ack_o = 0.
- R12: One rising edge on nmi_i yields exactly one acceptance, even if nmi_i then stays high.
- R13: accept_o is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_req_i | input | N_SRC | Interrupt condition per maskable source |
| src_en_i | input | N_SRC | Enable per maskable source |
| src_lvl_i | input | N_SRC | Priority level per source (1 = high) |
| nmi_i | input | 1 | Non-maskable interrupt, rising-edge sensitive |
| imask_i | input | 1 | Primary mask bit from the condition-code register |
| umask_i | input | 1 | Secondary mask bit from the condition-code register |
| insn_done_i | input | 1 | Instruction-boundary strobe |
| accept_o | output | 1 | One-cycle acceptance pulse |
| vec_o | output | VEC_W | Vector number of the accepted source |
| src_ack_o | output | N_SRC | One-hot acknowledge to the accepted maskable source |
| mask_set_o | output | 1 | Request to set both mask bits |

## Verification
The bench builds the arbiter with its defaults: eight sources, vector base 16, non-maskable vector 7 and 8-bit vectors. The tie-break checks can therefore use both end indices (0 and 7) as well as interior pairs, and every expected vector number is a small value computed from the index. With only eight sources, each of the three mask states can be combined with each level pattern in a short directed sequence, including a level-0 request left pending behind a level-1 winner.

// File: rtl/irq2_pkg.sv
package irq2_pkg;
  typedef enum logic [1:0] {
    MS_OPEN     = 2'd0,
    MS_HI_ONLY  = 2'd1,
    MS_NMI_ONLY = 2'd2
  } mask_state_e;

  function automatic mask_state_e decode_mask(input logic i_bit, input logic ui_bit);
    if (!i_bit)      return MS_OPEN;
    else if (!ui_bit) return MS_HI_ONLY;
    else             return MS_NMI_ONLY;
  endfunction
endpackage

// File: rtl/irq2_gate.sv
module irq2_gate #(
  parameter int N_SRC = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic             nmi_i,
  input  logic             nmi_clr_i,
  output logic [N_SRC-1:0] act_o,
  output logic             nmi_pend_o
);
  logic nmi_q, nmi_flag_q, nmi_rise;

  assign act_o      = src_req_i & src_en_i;
  assign nmi_rise   = nmi_i & ~nmi_q;
  assign nmi_pend_o = nmi_flag_q | nmi_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nmi_q      <= 1'b0;
      nmi_flag_q <= 1'b0;
    end else begin
      nmi_q      <= nmi_i;
      nmi_flag_q <= nmi_pend_o & ~nmi_clr_i;
    end
  end

  AST_NMI_HELD_UNTIL_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nmi_pend_o && !nmi_clr_i) |=> nmi_pend_o) else $error("nmi dropped"); // R12
endmodule

// File: rtl/irq2_select.sv
module irq2_select #(
  parameter int N_SRC = 8,
  localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] act_i,
  input  logic [N_SRC-1:0] lvl_i,
  input  logic             nmi_pend_i,
  output logic             valid_o,
  output logic             nmi_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             lvl_o
);
  logic [1:0]             hit;
  logic [1:0][IDX_W-1:0]  hit_idx;

  // one lowest-index finder per priority level
  for (genvar l = 0; l < 2; l++) begin : g_lvl
    logic [N_SRC-1:0] cand;
    assign cand = act_i & (l == 1 ? lvl_i : ~lvl_i);
    always_comb begin
      hit[l]     = 1'b0;
      hit_idx[l] = '0;
      for (int k = N_SRC - 1; k >= 0; k--) begin
        if (cand[k]) begin
          hit[l]     = 1'b1;
          hit_idx[l] = IDX_W'(k);
        end
      end
    end
  end

  always_comb begin
    nmi_o   = nmi_pend_i;
    valid_o = nmi_pend_i | hit[1] | hit[0];
    lvl_o   = hit[1];
    idx_o   = hit[1] ? hit_idx[1] : hit_idx[0];
  end
endmodule

// File: rtl/irq2_mask_chk.sv
module irq2_mask_chk
  import irq2_pkg::*;
(
  input  logic imask_i,
  input  logic umask_i,
  input  logic valid_i,
  input  logic nmi_i,
  input  logic lvl_i,
  output logic take_ok_o
);
  mask_state_e ms;

  always_comb begin
    ms = decode_mask(imask_i, umask_i);
    unique case (ms)
      MS_OPEN:     take_ok_o = valid_i;
      MS_HI_ONLY:  take_ok_o = valid_i & (nmi_i | lvl_i);
      default:     take_ok_o = valid_i & nmi_i;
    endcase
  end
endmodule

// File: rtl/irq2_arbiter.sv
module irq2_arbiter #(
  parameter int N_SRC    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 7,
  localparam int IDX_W   = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_req_i,
  input  logic [N_SRC-1:0] src_en_i,
  input  logic [N_SRC-1:0] src_lvl_i,
  input  logic             nmi_i,
  input  logic             imask_i,
  input  logic             umask_i,
  input  logic             insn_done_i,
  output logic             accept_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] src_ack_o,
  output logic             mask_set_o
);
  logic [N_SRC-1:0] act;
  logic             nmi_pend, sel_valid, sel_nmi, sel_lvl, take_ok, take;
  logic [IDX_W-1:0] sel_idx;
  logic             accept_q, acc_lvl_q;
  logic [VEC_W-1:0] vec_q;
  logic [N_SRC-1:0] ack_q;

  irq2_gate #(.N_SRC(N_SRC)) u_gate (
    .clk_i, .rst_ni, .src_req_i, .src_en_i, .nmi_i,
    .nmi_clr_i (take & sel_nmi),
    .act_o     (act),
    .nmi_pend_o(nmi_pend)
  );

  irq2_select #(.N_SRC(N_SRC)) u_sel (
    .act_i     (act),
    .lvl_i     (src_lvl_i),
    .nmi_pend_i(nmi_pend),
    .valid_o   (sel_valid),
    .nmi_o     (sel_nmi),
    .idx_o     (sel_idx),
    .lvl_o     (sel_lvl)
  );

  irq2_mask_chk u_mask (
    .imask_i, .umask_i,
    .valid_i  (sel_valid),
    .nmi_i    (sel_nmi),
    .lvl_i    (sel_lvl),
    .take_ok_o(take_ok)
  );

  // no new acceptance while the previous one is being taken by the CPU
  assign take = take_ok & insn_done_i & ~accept_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      accept_q  <= 1'b0;
      acc_lvl_q <= 1'b0;
      vec_q     <= '0;
      ack_q     <= '0;
    end else begin
      accept_q <= take;
      ack_q    <= '0;
      if (take) begin
        acc_lvl_q <= sel_lvl | sel_nmi;
        if (sel_nmi) begin
          vec_q <= VEC_W'(NMI_VEC);
        end else begin
          vec_q        <= VEC_W'(VEC_BASE) + VEC_W'(sel_idx);
          ack_q[sel_idx] <= 1'b1;
        end
      end
    end
  end

  assign accept_o   = accept_q;
  assign mask_set_o = accept_q;
  assign vec_o      = vec_q;
  assign src_ack_o  = ack_q;

  AST_ACCEPT_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> $past(insn_done_i)) else $error("accept off boundary"); // R9
  AST_NO_BACK_TO_BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !accept_o) else $error("back-to-back accept"); // R13
  AST_ACK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_ack_o) && (src_ack_o != '0 -> accept_o)) else $error("bad ack"); // R10
  AST_NMI_ONLY_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(imask_i) && $past(umask_i)) |-> (vec_o == VEC_W'(NMI_VEC) && src_ack_o == '0))
    else $error("maskable taken while fully masked"); // R8
  AST_HI_ONLY_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && $past(imask_i)) |-> acc_lvl_q) else $error("level-0 taken while masked"); // R7
  AST_ACK_SOURCE_ACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && src_ack_o != '0) |-> (($past(src_req_i & src_en_i) & src_ack_o) != '0))
    else $error("ack to inactive source"); // R2
endmodule

// File: tb/irq2_arbiter_tb.sv
module irq2_arbiter_tb;
  localparam int N = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] req = '0, en = '0, lvl = '0;
  logic nmi = 1'b0, im = 1'b0, um = 1'b0, done = 1'b0;
  logic accept, mset;
  logic [7:0] vec;
  logic [N-1:0] ack;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq2_arbiter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_req_i(req), .src_en_i(en), .src_lvl_i(lvl),
    .nmi_i(nmi), .imask_i(im), .umask_i(um), .insn_done_i(done),
    .accept_o(accept), .vec_o(vec), .src_ack_o(ack), .mask_set_o(mset)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // idle cycle, then one boundary cycle; outputs sampled at the negedge after
  task automatic step();
    done = 1'b0;
    @(posedge clk); @(negedge clk);
    done = 1'b1;
    @(posedge clk); @(negedge clk);
    done = 1'b0;
  endtask

  task automatic expect_take(input string rq, input int v, input int k);
    chk(accept === 1'b1, rq, accept, 1);
    chk(vec == 8'(v), rq, vec, v);
    chk(ack == ((k < 0) ? '0 : N'(1) << k), rq, ack, (k < 0) ? 0 : (1 << k));
    chk(mset === 1'b1, rq, mset, 1);
  endtask

  task automatic t_reset();
    chk(accept === 1'b0 && mset === 1'b0 && ack === '0, "R1", accept, 0);
  endtask

  task automatic t_gate();
    im = 0; um = 1; en = '0; req = 8'h10;
    step();
    chk(accept === 1'b0, "R2", accept, 0);
    en = 8'hFF;
    step();
    expect_take("R6", 20, 4);  // level 0 taken with I=0 despite UI=1
    req = '0; um = 0;
  endtask

  task automatic t_level();
    lvl = 8'h20; req = 8'h24;
    step();
    expect_take("R3", 21, 5);
    req = 8'h04;
    step();
    expect_take("R5", 18, 2);
    req = '0;
  endtask

  task automatic t_tie();
    lvl = 8'h81; req = 8'h81;
    step();
    expect_take("R4", 16, 0);
    lvl = '0; req = 8'h48;
    step();
    expect_take("R4", 19, 3);
    req = '0;
  endtask

  task automatic t_boundary();
    req = 8'h02; done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(accept === 1'b0, "R9", accept, 0);
    done = 1;
    @(posedge clk); @(negedge clk);
    done = 0;
    expect_take("R9", 17, 1);
    @(posedge clk); @(negedge clk);
    chk(accept === 1'b0, "R9", accept, 0);
    req = '0;
  endtask

  task automatic t_hi_only();
    im = 1; um = 0; lvl = 8'h40; req = 8'h04;
    step();
    chk(accept === 1'b0, "R7", accept, 0);
    req = 8'h44;
    step();
    expect_take("R7", 22, 6);
    req = 8'h04;
    step();
    chk(accept === 1'b0, "R7", accept, 0);
    req = '0;
  endtask

  task automatic t_nmi();
    im = 1; um = 1; lvl = 8'h40; req = 8'h40;
    step();
    chk(accept === 1'b0, "R8", accept, 0);
    nmi = 1;
    step();
    expect_take("R8", 7, -1);
    step();
    chk(accept === 1'b0, "R12", accept, 0);
    nmi = 0; im = 0; um = 0; lvl = 8'h01; req = 8'h41;
    @(negedge clk);
    nmi = 1;
    step();
    expect_take("R11", 7, -1);
    nmi = 0; req = '0;
  endtask

  task automatic t_b2b();
    im = 0; req = 8'h08; done = 0;
    @(posedge clk); @(negedge clk);
    done = 1;
    @(posedge clk); @(negedge clk);
    chk(accept === 1'b1, "R13", accept, 1);
    @(posedge clk); @(negedge clk);
    chk(accept === 1'b0, "R13", accept, 0);
    done = 0; req = '0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_gate();
    t_level();
    t_tie();
    t_boundary();
    t_hi_only();
    t_nmi();
    t_b2b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule